// File: doc/BRIEF.md
# Interrupt Class Delivery Sequencer

This block chooses which interrupt class a processor takes next and keeps delivering until nothing more can be delivered. A chain starts when the core raises a hard-interrupt request while no execute-target instruction is in flight. The block hands one class at a time to a downstream handler with a one-cycle command pulse. It waits for that handler's completion strobe, then looks at the classes again. Memory traffic belongs to the handlers and is outside this block.

A synchronous exception (program check or supervisor call) that is present when the chain starts goes out first. After it, the asynchronous classes compete in fixed order. Delivering a stop ends the chain at once. When the chain ends, the block raises one-cycle pulses for halt, unhalt and clearing of the hard request. These depend on the PSW wait bit, whether a stop was taken, whether the core is halted, and whether any interrupt is still pending.

Command and completion vectors share one layout. Bit 0 is program check and bit 1 is supervisor call. Bits 2 to 6 are machine check, external, I/O, restart and stop. On the asynchronous flag input, bit 0 is machine check and bit 4 is stop.

Top module: `irq_class_seq`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `dlv_o`, `halt_o`, `unhalt_o` and `hard_clr_o` are all zero.
- R2: A chain starts only from the idle state, on a cycle with `req_i` high and `exec_busy_i` low. While `exec_busy_i` is high, a request starts nothing and no command is issued.
- R3: If any bit of `sync_req_i` is set when the chain samples its first selection, the first command is a synchronous class (program check, bit 0, wins over supervisor call, bit 1), even when asynchronous flags are also set.
- R4: Asynchronous selection takes the highest-priority set flag. The order is machine check, then external, then I/O, then restart, then stop. These map to command bits 2, 3, 4, 5 and 6.
- R5: After a completed delivery of any class other than stop, the flags are sampled again and the next class is delivered. Synchronous requests are considered only in the first selection of a chain.
- R6: After a stop delivery completes, no further command is issued in that chain, even if flags are set.
- R7: Each command is a one-cycle, one-hot pulse on `dlv_o`. No further command appears until `done_i` shows the bit of the class just issued. A completion bit for any other class is ignored.
- R8: At the end of a chain, `halt_o` pulses for one cycle if `wait_bit_i` is high or a stop was delivered.
- R9: At the end of a chain, `unhalt_o` pulses if `halt_o` does not and `halted_i` is high.
- R10: At the end of a chain, `hard_clr_o` pulses if and only if `any_pending_i` is low.
- R11: A chain that finds nothing deliverable issues no command and still produces its end-of-chain outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Hard-interrupt request from the core |
| exec_busy_i | input | 1 | Execute-target instruction in progress; blocks acceptance |
| sync_req_i | input | NUM_SYNC | Pending synchronous exceptions (bit 0 program, bit 1 supervisor call) |
| async_req_i | input | NUM_ASYNC | Deliverable asynchronous classes, index 0 highest priority, top index stop |
| done_i | input | NUM_SYNC+NUM_ASYNC | Handler completion strobes, one per class |
| wait_bit_i | input | 1 | Wait bit of the PSW after delivery |
| halted_i | input | 1 | Processor currently halted |
| any_pending_i | input | 1 | Some interrupt, deliverable or not, is still pending |
| busy_o | output | 1 | A chain is in progress |
| dlv_o | output | NUM_SYNC+NUM_ASYNC | One-cycle delivery command, one bit per class |
| halt_o | output | 1 | Halt request pulse at end of chain |
| unhalt_o | output | 1 | Unhalt request pulse at end of chain |
| hard_clr_o | output | 1 | Drop-hard-request pulse at end of chain |

## Verification
Every cycle, the assertions check the following:
- command pulses are one-hot and last one cycle;
- no command is issued between a command and its matching completion, or after a stop in the same chain;
- no chain starts while an execute target is in progress;
- halt and unhalt never fire together;
- unhalt fires only for a halted core with a clear wait bit.

The bench scenarios cover what a single cycle cannot show:
- the order of classes across a whole chain;
- that a synchronous exception goes first and is not offered again;
- that flags arriving after a stop go undelivered;
- which end-of-chain pulses appear for each combination of wait bit, stop, halted state and pending interrupts.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_SELECT    = 3'd1,
      ST_DISPATCH  = 3'd2,
      ST_WAIT_DONE = 3'd3,
      ST_FINISH    = 3'd4
   } seq_state_e;
endpackage

// File: rtl/irq_seq_prio.sv
// Fixed-priority picker: lowest set index wins, output is one-hot.
module irq_seq_prio #(
   parameter int W = 4
) (
   input  logic [W-1:0] req_i,
   output logic [W-1:0] grant_o,
   output logic         any_o
);
   logic [W:0] seen;
   assign seen[0] = 1'b0;
   generate
      for (genvar i = 0; i < W; i++) begin : g_chain
         assign grant_o[i]  = req_i[i] & ~seen[i];
         assign seen[i+1]   = seen[i] | req_i[i];
      end
   endgenerate
   assign any_o = seen[W];
endmodule

// File: rtl/irq_seq_finish.sv
// End-of-chain decision: halt, unhalt and hard-request clear.
module irq_seq_finish (
   input  logic stopped_i,
   input  logic wait_bit_i,
   input  logic halted_i,
   input  logic any_pending_i,
   output logic halt_req_o,
   output logic unhalt_req_o,
   output logic clr_req_o
);
   always_comb begin
      halt_req_o   = wait_bit_i | stopped_i;
      unhalt_req_o = ~halt_req_o & halted_i;
      clr_req_o    = ~any_pending_i;
   end
endmodule

// File: rtl/irq_class_seq.sv
module irq_class_seq #(
   parameter int NUM_SYNC  = 2,
   parameter int NUM_ASYNC = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_i,
   input  logic                            exec_busy_i,
   input  logic [NUM_SYNC-1:0]             sync_req_i,
   input  logic [NUM_ASYNC-1:0]            async_req_i,
   input  logic [NUM_SYNC+NUM_ASYNC-1:0]   done_i,
   input  logic                            wait_bit_i,
   input  logic                            halted_i,
   input  logic                            any_pending_i,
   output logic                            busy_o,
   output logic [NUM_SYNC+NUM_ASYNC-1:0]   dlv_o,
   output logic                            halt_o,
   output logic                            unhalt_o,
   output logic                            hard_clr_o
);
   import irq_seq_pkg::*;

   localparam int NUM_CLS  = NUM_SYNC + NUM_ASYNC;
   localparam int STOP_IDX = NUM_CLS - 1;

   generate
      if (NUM_SYNC < 1) begin : g_bad_sync
         $error("irq_class_seq: NUM_SYNC must be at least 1");
      end
      if (NUM_ASYNC < 2) begin : g_bad_async
         $error("irq_class_seq: NUM_ASYNC must be at least 2");
      end
   endgenerate

   seq_state_e          state_q;
   logic                first_q;
   logic                stop_q;
   logic [NUM_CLS-1:0]  sel_q;

   logic [NUM_SYNC-1:0]  sync_grant;
   logic [NUM_ASYNC-1:0] async_grant;
   logic                 sync_any;
   logic                 async_any;
   logic [NUM_CLS-1:0]   next_sel;
   logic                 pick_any;
   logic                 done_hit;

   irq_seq_prio #(.W(NUM_SYNC)) u_sync_prio (
      .req_i   (sync_req_i),
      .grant_o (sync_grant),
      .any_o   (sync_any)
   );

   irq_seq_prio #(.W(NUM_ASYNC)) u_async_prio (
      .req_i   (async_req_i),
      .grant_o (async_grant),
      .any_o   (async_any)
   );

   always_comb begin
      if (first_q && sync_any) begin
         next_sel = {{NUM_ASYNC{1'b0}}, sync_grant};
         pick_any = 1'b1;
      end else begin
         next_sel = {async_grant, {NUM_SYNC{1'b0}}};
         pick_any = async_any;
      end
      done_hit = |(done_i & sel_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         first_q <= 1'b0;
         stop_q  <= 1'b0;
         sel_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_i && !exec_busy_i) begin
                  state_q <= ST_SELECT;
                  first_q <= 1'b1;
                  stop_q  <= 1'b0;
               end
            end
            ST_SELECT: begin
               first_q <= 1'b0;
               if (pick_any) begin
                  sel_q   <= next_sel;
                  state_q <= ST_DISPATCH;
               end else begin
                  sel_q   <= '0;
                  state_q <= ST_FINISH;
               end
            end
            ST_DISPATCH: begin
               state_q <= ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
               if (done_hit) begin
                  if (sel_q[STOP_IDX]) begin
                     stop_q  <= 1'b1;
                     state_q <= ST_FINISH;
                  end else begin
                     state_q <= ST_SELECT;
                  end
               end
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic halt_req, unhalt_req, clr_req;

   irq_seq_finish u_finish (
      .stopped_i     (stop_q),
      .wait_bit_i    (wait_bit_i),
      .halted_i      (halted_i),
      .any_pending_i (any_pending_i),
      .halt_req_o    (halt_req),
      .unhalt_req_o  (unhalt_req),
      .clr_req_o     (clr_req)
   );

   logic in_finish;
   assign in_finish  = (state_q == ST_FINISH);
   assign busy_o     = (state_q != ST_IDLE);
   assign dlv_o      = (state_q == ST_DISPATCH) ? sel_q : '0;
   assign halt_o     = in_finish & halt_req;
   assign unhalt_o   = in_finish & unhalt_req;
   assign hard_clr_o = in_finish & clr_req;
endmodule

// File: rtl/irq_class_seq_chk.sv
module irq_class_seq_chk #(
   parameter int NUM_SYNC  = 2,
   parameter int NUM_ASYNC = 5
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          exec_busy_i,
   input logic [NUM_SYNC+NUM_ASYNC-1:0] done_i,
   input logic                          wait_bit_i,
   input logic                          halted_i,
   input logic                          busy_o,
   input logic [NUM_SYNC+NUM_ASYNC-1:0] dlv_o,
   input logic                          halt_o,
   input logic                          unhalt_o,
   input logic                          hard_clr_o
);
   localparam int NC = NUM_SYNC + NUM_ASYNC;

   logic          stop_seen;
   logic          waiting;
   logic [NC-1:0] last_cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_seen <= 1'b0;
         waiting   <= 1'b0;
         last_cmd  <= '0;
      end else begin
         if (dlv_o[NC-1]) stop_seen <= 1'b1;
         else if (!busy_o) stop_seen <= 1'b0;
         if (dlv_o != '0) begin
            waiting  <= 1'b1;
            last_cmd <= dlv_o;
         end else if (|(done_i & last_cmd)) begin
            waiting  <= 1'b0;
         end
      end
   end

   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (dlv_o == '0 && !halt_o && !unhalt_o && !hard_clr_o));

   a_r2_no_start_exec: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> !$past(exec_busy_i));

   a_r6_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |-> dlv_o == '0);

   a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dlv_o));

   a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_o != '0) |=> (dlv_o == '0));

   a_r7_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> dlv_o == '0);

   a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_o && unhalt_o));

   a_r9_unhalt_cond: assert property (@(posedge clk) disable iff (!rst_n)
      unhalt_o |-> (halted_i && !wait_bit_i));
endmodule

bind irq_class_seq irq_class_seq_chk #(
   .NUM_SYNC  (NUM_SYNC),
   .NUM_ASYNC (NUM_ASYNC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exec_busy_i (exec_busy_i),
   .done_i      (done_i),
   .wait_bit_i  (wait_bit_i),
   .halted_i    (halted_i),
   .busy_o      (busy_o),
   .dlv_o       (dlv_o),
   .halt_o      (halt_o),
   .unhalt_o    (unhalt_o),
   .hard_clr_o  (hard_clr_o)
);

// File: tb/tb_irq_class_seq.sv
module tb_irq_class_seq;
   localparam int NS = 2;
   localparam int NA = 5;
   localparam int NC = NS + NA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic          exec_busy_i = 1'b0;
   logic [NS-1:0] sync_req_i = '0;
   logic [NA-1:0] async_req_i = '0;
   logic [NC-1:0] done_i = '0;
   logic          wait_bit_i = 1'b0;
   logic          halted_i = 1'b0;
   logic          any_pending_i = 1'b0;
   logic          busy_o;
   logic [NC-1:0] dlv_o;
   logic          halt_o, unhalt_o, hard_clr_o;

   int total = 0;
   int bad = 0;
   int n_dlv;
   int seq_log [0:15];
   int saw_halt, saw_unhalt, saw_clr;

   always #5 clk = ~clk;

   irq_class_seq #(.NUM_SYNC(NS), .NUM_ASYNC(NA)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .exec_busy_i(exec_busy_i),
      .sync_req_i(sync_req_i), .async_req_i(async_req_i), .done_i(done_i),
      .wait_bit_i(wait_bit_i), .halted_i(halted_i), .any_pending_i(any_pending_i),
      .busy_o(busy_o), .dlv_o(dlv_o), .halt_o(halt_o), .unhalt_o(unhalt_o),
      .hard_clr_o(hard_clr_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int cls_index(input logic [NC-1:0] v);
      int r = -1;
      for (int i = 0; i < NC; i++) if (v[i]) r = i;
      return r;
   endfunction

   // Starts a chain and plays the handlers; wrong_done sends a foreign
   // completion first; inject_ext sets the external flag when stop is handled.
   task automatic run_chain(input bit wrong_done, input bit inject_ext);
      int idx;
      n_dlv = 0; saw_halt = 0; saw_unhalt = 0; saw_clr = 0;
      @(negedge clk) req_i = 1'b1;
      @(negedge clk) req_i = 1'b0;
      for (int cyc = 0; cyc < 80; cyc++) begin
         if (halt_o)     saw_halt++;
         if (unhalt_o)   saw_unhalt++;
         if (hard_clr_o) saw_clr++;
         if (!busy_o) break;
         if (dlv_o != '0) begin
            idx = cls_index(dlv_o);
            if (n_dlv < 16) seq_log[n_dlv] = idx;
            n_dlv++;
            @(negedge clk);
            check("R7 pulse one cycle", int'(dlv_o), 0);
            if (wrong_done) begin
               done_i = '0;
               done_i[(idx + 1) % NC] = 1'b1;
               @(negedge clk) done_i = '0;
               repeat (2) begin
                  @(negedge clk);
                  check("R7 foreign done ignored, no command", int'(dlv_o), 0);
                  check("R7 foreign done ignored, still busy", int'(busy_o), 1);
               end
            end
            done_i = '0;
            done_i[idx] = 1'b1;
            if (idx < NS) sync_req_i[idx] = 1'b0;
            else async_req_i[idx - NS] = 1'b0;
            if (idx == NC - 1 && inject_ext) async_req_i[1] = 1'b1;
            @(negedge clk) done_i = '0;
         end else begin
            @(negedge clk);
         end
      end
   endtask

   task automatic t_reset;
      check("R1 busy at reset", int'(busy_o), 0);
      check("R1 dlv at reset", int'(dlv_o), 0);
      check("R1 end pulses at reset", int'({halt_o, unhalt_o, hard_clr_o}), 0);
   endtask

   task automatic t_async_order;
      // mchk (bit0), ext (bit1), io (bit2) pending
      async_req_i = 5'b00111; wait_bit_i = 0; halted_i = 0; any_pending_i = 0;
      run_chain(0, 0);
      check("R4 count", n_dlv, 3);
      check("R4 first is machine check", seq_log[0], 2);
      check("R5 second is external", seq_log[1], 3);
      check("R5 third is io", seq_log[2], 4);
      check("R8 no halt", saw_halt, 0);
      check("R10 clear when none pending", saw_clr, 1);
   endtask

   task automatic t_sync_first;
      sync_req_i = 2'b11; async_req_i = 5'b00010; any_pending_i = 1;
      run_chain(0, 0);
      check("R3 count", n_dlv, 2);
      check("R3 program check first", seq_log[0], 0);
      check("R5 sync not revisited, external next", seq_log[1], 3);
      check("R10 no clear while pending", saw_clr, 0);
      sync_req_i = '0;
   endtask

   task automatic t_stop;
      async_req_i = 5'b11000; any_pending_i = 0;
      run_chain(0, 1);
      check("R4 restart before stop", seq_log[0], 5);
      check("R4 stop delivered", seq_log[1], 6);
      check("R6 nothing after stop", n_dlv, 2);
      check("R8 halt after stop", saw_halt, 1);
      check("R9 no unhalt after stop", saw_unhalt, 0);
      check("R6 injected flag left undelivered", int'(async_req_i[1]), 1);
      async_req_i = '0;
   endtask

   task automatic t_wait_bit;
      async_req_i = 5'b00100; wait_bit_i = 1; halted_i = 1;
      run_chain(0, 0);
      check("R8 io delivered", seq_log[0], 4);
      check("R8 halt on wait bit", saw_halt, 1);
      check("R9 no unhalt with wait bit", saw_unhalt, 0);
      wait_bit_i = 0;
   endtask

   task automatic t_empty_unhalt;
      async_req_i = '0; halted_i = 1; any_pending_i = 1;
      run_chain(0, 0);
      check("R11 no command", n_dlv, 0);
      check("R9 unhalt halted core", saw_unhalt, 1);
      check("R11 no halt", saw_halt, 0);
      check("R10 no clear while pending", saw_clr, 0);
      halted_i = 0; any_pending_i = 0;
   endtask

   task automatic t_exec_busy;
      async_req_i = 5'b00001; exec_busy_i = 1;
      @(negedge clk) req_i = 1;
      repeat (4) begin
         @(negedge clk);
         check("R2 refused while exec busy", int'(busy_o), 0);
         check("R2 no command while exec busy", int'(dlv_o), 0);
      end
      req_i = 0; exec_busy_i = 0;
      @(negedge clk);
      run_chain(0, 0);
      check("R2 accepted after exec ends", n_dlv, 1);
   endtask

   task automatic t_wrong_done;
      async_req_i = 5'b01000;
      run_chain(1, 0);
      check("R7 restart delivered once", n_dlv, 1);
      check("R7 restart class", seq_log[0], 5);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_async_order();
      t_sync_first();
      t_stop();
      t_wait_bit();
      t_empty_unhalt();
      t_exec_busy();
      t_wrong_done();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule